// File: doc/BRIEF.md
# Event and Cycle Performance Counter Block

This block counts hardware events and clock cycles for performance analysis. It holds one free-running cycle counter and two 32-bit event counters. Each event counter picks one 8-bit event code, and on every clock in which the pulse line with that index is high it advances by one. All configuration lives in one packed control word: the global run bit, two self-clearing zeroing strobes, a divide-by-64 option for the cycle counter, one interrupt enable per counter, one sticky wrap flag per counter and both event selectors.

Software reaches the control word and the three counters over a plain register bus with a write strobe, a 2-bit address and 32-bit data. Reads return the addressed register combinationally. A counter that wraps from all ones to zero raises its flag. The interrupt output is a level that stays high while any raised flag has its enable set. Flags are cleared by writing ones to their positions, so writing back a control word just read clears exactly the flags that were seen.

Top module: `perfmon_unit`

## Requirements
- R1: After reset the control word, all three counters and `irq` read as zero.
- R2: Control field positions: bit 0 run, bit 3 cycle divide, bits 4/5/6 interrupt enables for event counter 0, event counter 1 and the cycle counter, bits 8/9/10 their wrap flags, bits 19:12 the code of event counter 0, bits 27:20 the code of event counter 1. Bits 1, 2, 7, 11 and 31:28 always read as zero.
- R3: While run is 1, an event counter advances by one on each clock in which `evt_pulse[code]` is high for its selected code; pulses on other codes leave it unchanged.
- R4: An event counter whose selected code is 0xFF never advances, even when `evt_pulse[255]` is high.
- R5: While run is 0, no counter advances.
- R6: While run is 1 the cycle counter advances every clock when the divide bit is 0, and once every 64 running clocks when it is 1; the divider holds its phase while run is 0.
- R7: Writing 1 to control bit 1 zeroes both event counters; writing 1 to control bit 2 zeroes the cycle counter and its divider. Neither touches the other counters.
- R8: A counter that advances from 0xFFFFFFFF reads 0 and sets its wrap flag.
- R9: A control write clears every wrap flag at whose position it writes 1 and leaves flags written with 0 set.
- R10: `irq` is high exactly while some wrap flag is set together with its interrupt enable.
- R11: A bus write to a counter in the same clock as an advance stores the written value and sets no flag.
- R12: Address 0 is the control word, 1 the cycle counter, 2 event counter 0 and 3 event counter 1; each counter is readable and writable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register |
| evt_pulse | input | 256 | One-cycle event pulses, indexed by event code |
| irq | output | 1 | Level interrupt |

## Verification
Counting is tried with bursts of different lengths on the two selected codes and on an unselected code, which tells apart a counter bound to the wrong field or to the wrong pulse line. The unused code 0xFF is driven with its own pulse line high, separating a true "never counts" from a plain index lookup. The divided cycle counter is stopped one clock short of its first advance and then resumed, which shows both the 64-clock period and that the divider keeps its phase while halted. Wrap, flag clearing with zero and with one bits, and a counter write colliding with an event pulse cover the flag and interrupt path.

// File: rtl/perfmon_pkg.sv
package perfmon_pkg;

  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 2;
  localparam int CODE_W    = 8;
  localparam int NUM_CODES = 1 << CODE_W;
  localparam int NUM_EVT   = 2;
  localparam int NUM_SLOT  = NUM_EVT + 1;
  localparam int CYC_SLOT  = NUM_EVT;
  localparam int DIV_LOG2  = 6;

  localparam logic [CODE_W-1:0] CODE_IDLE = '1;

  // control word bit positions
  localparam int CB_RUN     = 0;
  localparam int CB_ZAP_EVT = 1;
  localparam int CB_ZAP_CYC = 2;
  localparam int CB_DIV     = 3;
  localparam int CB_IE      = 4;
  localparam int CB_WRAP    = 8;
  localparam int CB_SEL     = 12;

  typedef enum logic [ADDR_W-1:0] {
    RA_CTRL = 2'd0,
    RA_CYC  = 2'd1,
    RA_EV0  = 2'd2,
    RA_EV1  = 2'd3
  } reg_addr_e;

  // bits that carry stored state and read back
  function automatic logic [DATA_W-1:0] ctrl_read_mask();
    logic [DATA_W-1:0] m;
    m = '0;
    m[CB_RUN] = 1'b1;
    m[CB_DIV] = 1'b1;
    for (int s = 0; s < NUM_SLOT; s++) begin
      m[CB_IE + s]   = 1'b1;
      m[CB_WRAP + s] = 1'b1;
    end
    for (int e = 0; e < NUM_EVT * CODE_W; e++) m[CB_SEL + e] = 1'b1;
    return m;
  endfunction

  // bits that a control write acts upon
  function automatic logic [DATA_W-1:0] ctrl_write_mask();
    logic [DATA_W-1:0] m;
    m = ctrl_read_mask();
    m[CB_ZAP_EVT] = 1'b1;
    m[CB_ZAP_CYC] = 1'b1;
    return m;
  endfunction

  function automatic logic [ADDR_W-1:0] slot_addr(input int s);
    if (s == CYC_SLOT) return RA_CYC;
    return ADDR_W'(RA_EV0 + s);
  endfunction

endpackage

// File: rtl/perfmon_counter.sv
module perfmon_counter
  import perfmon_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         clr,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] value,
  output logic         wrap
);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_ld;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_ld = 1'b0;
    if (wr_en) begin
      cnt_d  = wr_data;
      cnt_ld = 1'b1;
    end else if (clr) begin
      cnt_d  = '0;
      cnt_ld = 1'b1;
    end else if (inc) begin
      cnt_d  = cnt_q + W'(1);
      cnt_ld = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_ld) cnt_q <= cnt_d;
  end

  assign value = cnt_q;
  assign wrap  = inc && !wr_en && !clr && (&cnt_q);

  assert_write_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (value == $past(wr_data)));

  assert_wrap_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !wr_en && !clr && (&value)) |=> (value == '0));

  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !wr_en && !clr) |=> $stable(value));

  assert_zap_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !wr_en) |=> (value == '0));

endmodule

// File: rtl/perfmon_prescaler.sv
module perfmon_prescaler
  import perfmon_pkg::*;
#(
  parameter int LOG2 = DIV_LOG2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic div_on,
  input  logic clr,
  output logic tick
);

  logic [LOG2-1:0] ph_q, ph_d;
  logic            ph_ld;

  always_comb begin
    ph_d  = ph_q;
    ph_ld = 1'b0;
    if (clr || !div_on) begin
      ph_d  = '0;
      ph_ld = 1'b1;
    end else if (run) begin
      ph_d  = ph_q + LOG2'(1);
      ph_ld = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else if (ph_ld) ph_q <= ph_d;
  end

  assign tick = run && div_on && !clr && (&ph_q);

  assert_tick_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/perfmon_ctrl.sv
module perfmon_ctrl
  import perfmon_pkg::*;
(
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [DATA_W-1:0]                 wr_data,
  input  logic [NUM_SLOT-1:0]               wrap_set,
  output logic                              run,
  output logic                              div_on,
  output logic                              zap_evt,
  output logic                              zap_cyc,
  output logic [NUM_EVT-1:0][CODE_W-1:0]    sel,
  output logic [DATA_W-1:0]                 rd_word,
  output logic                              irq
);

  localparam logic [DATA_W-1:0] WR_MASK = ctrl_write_mask();

  logic                           run_q, run_d;
  logic                           div_q, div_d;
  logic [NUM_SLOT-1:0]            ie_q, ie_d;
  logic [NUM_SLOT-1:0]            wrap_q, wrap_d;
  logic [NUM_EVT-1:0][CODE_W-1:0] sel_q, sel_d;
  logic [NUM_SLOT-1:0]            wrap_clr;
  logic                           unused_rsvd;

  assign unused_rsvd = ^(wr_data & ~WR_MASK);

  always_comb begin
    run_d = run_q;
    div_d = div_q;
    ie_d  = ie_q;
    sel_d = sel_q;
    if (wr_en) begin
      run_d = wr_data[CB_RUN];
      div_d = wr_data[CB_DIV];
      ie_d  = wr_data[CB_IE +: NUM_SLOT];
      for (int i = 0; i < NUM_EVT; i++)
        sel_d[i] = wr_data[CB_SEL + i * CODE_W +: CODE_W];
    end
    wrap_clr = wr_en ? wr_data[CB_WRAP +: NUM_SLOT] : '0;
    wrap_d   = (wrap_q & ~wrap_clr) | wrap_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      div_q <= 1'b0;
      ie_q  <= '0;
      sel_q <= '0;
    end else if (wr_en) begin
      run_q <= run_d;
      div_q <= div_d;
      ie_q  <= ie_d;
      sel_q <= sel_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wrap_q <= '0;
    else        wrap_q <= wrap_d;
  end

  always_comb begin
    rd_word = '0;
    rd_word[CB_RUN] = run_q;
    rd_word[CB_DIV] = div_q;
    rd_word[CB_IE +: NUM_SLOT]   = ie_q;
    rd_word[CB_WRAP +: NUM_SLOT] = wrap_q;
    for (int i = 0; i < NUM_EVT; i++)
      rd_word[CB_SEL + i * CODE_W +: CODE_W] = sel_q[i];
  end

  assign run     = run_q;
  assign div_on  = div_q;
  assign sel     = sel_q;
  assign zap_evt = wr_en && wr_data[CB_ZAP_EVT];
  assign zap_cyc = wr_en && wr_data[CB_ZAP_CYC];
  assign irq     = |(wrap_q & ie_q);

  for (genvar s = 0; s < NUM_SLOT; s++) begin : g_flag_chk
    assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap_q[s] && !(wr_en && wr_data[CB_WRAP + s])) |=> wrap_q[s]);
  end

  assert_irq_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (&wr_data[CB_WRAP +: NUM_SLOT]) && (wrap_set == '0)) |=> !irq);

endmodule

// File: rtl/perfmon_unit.sv
module perfmon_unit
  import perfmon_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic [NUM_CODES-1:0] evt_pulse,
  output logic                 irq
);

  localparam logic [DATA_W-1:0] RD_MASK = ctrl_read_mask();

  logic                           run, div_on, zap_evt, zap_cyc, tick;
  logic [NUM_EVT-1:0][CODE_W-1:0] sel;
  logic [DATA_W-1:0]              ctrl_word;
  logic [NUM_SLOT-1:0]            cnt_inc, cnt_clr, cnt_wr, cnt_wrap;
  logic [NUM_SLOT-1:0][DATA_W-1:0] cnt_val;

  perfmon_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (bus_wr && (bus_addr == RA_CTRL)),
    .wr_data  (bus_wdata),
    .wrap_set (cnt_wrap),
    .run      (run),
    .div_on   (div_on),
    .zap_evt  (zap_evt),
    .zap_cyc  (zap_cyc),
    .sel      (sel),
    .rd_word  (ctrl_word),
    .irq      (irq)
  );

  perfmon_prescaler #(.LOG2(DIV_LOG2)) u_presc (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run),
    .div_on (div_on),
    .clr    (zap_cyc),
    .tick   (tick)
  );

  for (genvar s = 0; s < NUM_SLOT; s++) begin : g_slot
    if (s == CYC_SLOT) begin : g_cyc
      assign cnt_inc[s] = run && (!div_on || tick);
      assign cnt_clr[s] = zap_cyc;
    end else begin : g_evt
      assign cnt_inc[s] = run && (sel[s] != CODE_IDLE) && evt_pulse[sel[s]];
      assign cnt_clr[s] = zap_evt;
    end
    assign cnt_wr[s] = bus_wr && (bus_addr == slot_addr(s));

    perfmon_counter #(.W(DATA_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc     (cnt_inc[s]),
      .clr     (cnt_clr[s]),
      .wr_en   (cnt_wr[s]),
      .wr_data (bus_wdata),
      .value   (cnt_val[s]),
      .wrap    (cnt_wrap[s])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == RA_CTRL) bus_rdata = ctrl_word;
    for (int s = 0; s < NUM_SLOT; s++)
      if (bus_addr == slot_addr(s)) bus_rdata = cnt_val[s];
  end

  assert_ctrl_rsvd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == RA_CTRL) |-> ((bus_rdata & ~RD_MASK) == '0));

  assert_halt_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !bus_wr) |=> $stable(cnt_val));

endmodule

// File: tb/perfmon_unit_test.sv
module perfmon_unit_test;

  logic         clk;
  logic         rst_n;
  logic         bus_wr;
  logic [1:0]   bus_addr;
  logic [31:0]  bus_wdata;
  logic [31:0]  bus_rdata;
  logic [255:0] evt_pulse;
  logic         irq;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  typedef struct {
    bit          is_irq;
    logic [1:0]  addr;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  perfmon_unit uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .evt_pulse (evt_pulse),
    .irq       (irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // monitor: compares queued expectations away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        checks++;
        if (it.is_irq) begin
          if (irq !== it.exp[0]) begin
            errors++;
            $display("FAIL %s irq got %0b expected %0b", it.tag, irq, it.exp[0]);
          end
        end else if (bus_rdata !== it.exp) begin
          errors++;
          $display("FAIL %s addr %0d got %h expected %h", it.tag, it.addr, bus_rdata, it.exp);
        end
      end
    end
  end

  // all tasks start and end at a falling edge
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic expect_reg(input logic [1:0] a, input logic [31:0] e, input string tag);
    item_t it;
    bus_addr = a;
    it.is_irq = 1'b0; it.addr = a; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
  endtask

  task automatic expect_irq(input bit e, input string tag);
    item_t it;
    it.is_irq = 1'b1; it.addr = '0; it.exp = {31'd0, e}; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
  endtask

  task automatic pulse(input int code, input int n);
    evt_pulse[code] = 1'b1;
    repeat (n) @(negedge clk);
    evt_pulse[code] = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; evt_pulse = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state, R12 address map
    expect_reg(2'd0, 32'h0, "R1 ctrl");
    expect_reg(2'd1, 32'h0, "R1 cycle");
    expect_reg(2'd2, 32'h0, "R1 event0");
    expect_reg(2'd3, 32'h0, "R1 event1");
    expect_irq(1'b0, "R1 irq");

    // R2 reserved and strobe bits read zero; sel0=07 sel1=05, run
    wr(2'd0, 32'hF050_7887);
    expect_reg(2'd0, 32'h0050_7001, "R2 ctrl readback");
    wr(2'd0, 32'h0050_7000);
    expect_reg(2'd1, 32'd2, "R6 cycle every clock");

    // R3 counting on selected codes only
    wr(2'd0, 32'h0050_7007);
    pulse(7, 5);
    pulse(5, 3);
    pulse(0, 4);
    wr(2'd0, 32'h0050_7000);
    expect_reg(2'd2, 32'd5, "R3 event0 code 07");
    expect_reg(2'd3, 32'd3, "R3 event1 code 05");
    expect_reg(2'd1, 32'd13, "R6 cycle count");

    // R5 halted
    pulse(7, 6);
    expect_reg(2'd2, 32'd5, "R5 event0 halted");
    expect_reg(2'd1, 32'd13, "R5 cycle halted");

    // R4 code FF never counts
    wr(2'd0, 32'h0FF0_7001);
    pulse(255, 4);
    pulse(7, 2);
    wr(2'd0, 32'h0FF0_7000);
    expect_reg(2'd3, 32'd3, "R4 event1 idle code");
    expect_reg(2'd2, 32'd7, "R3 event0 after resume");

    // R7 zeroing strobes
    wr(2'd0, 32'h0FF0_7002);
    expect_reg(2'd2, 32'd0, "R7 event0 zeroed");
    expect_reg(2'd3, 32'd0, "R7 event1 zeroed");
    expect_reg(2'd1, 32'd20, "R7 cycle untouched");
    wr(2'd0, 32'h0FF0_7004);
    expect_reg(2'd1, 32'd0, "R7 cycle zeroed");

    // R6 divide by 64 with phase held while halted
    wr(2'd0, 32'h0FF0_700D);
    repeat (62) @(negedge clk);
    wr(2'd0, 32'h0FF0_7008);
    expect_reg(2'd1, 32'd0, "R6 no advance after 63 clocks");
    wr(2'd0, 32'h0FF0_7009);
    wr(2'd0, 32'h0FF0_7008);
    expect_reg(2'd1, 32'd1, "R6 advance on 64th clock");

    // R8 wrap of event counter 0, R10 irq
    wr(2'd2, 32'hFFFF_FFFE);
    wr(2'd0, 32'h0FF0_7011);
    pulse(7, 2);
    wr(2'd0, 32'h0FF0_7010);
    expect_reg(2'd2, 32'd0, "R8 event0 wrapped");
    expect_reg(2'd0, 32'h0FF0_7110, "R8 flag bit 8");
    expect_irq(1'b1, "R10 irq raised");

    // R9 zero write keeps flag, R10 enable off drops irq
    wr(2'd0, 32'h0FF0_7000);
    expect_irq(1'b0, "R10 irq masked");
    expect_reg(2'd0, 32'h0FF0_7100, "R9 flag kept");
    wr(2'd0, 32'h0FF0_7110);
    expect_reg(2'd0, 32'h0FF0_7010, "R9 flag cleared");
    expect_irq(1'b0, "R9 irq after clear");

    // R8 cycle counter wrap, flag bit 10
    wr(2'd1, 32'hFFFF_FFFF);
    wr(2'd0, 32'h0FF0_7041);
    wr(2'd0, 32'h0FF0_7040);
    expect_reg(2'd1, 32'd0, "R8 cycle wrapped");
    expect_reg(2'd0, 32'h0FF0_7440, "R8 flag bit 10");
    expect_irq(1'b1, "R10 irq from cycle");
    wr(2'd0, 32'h0FF0_7400);
    expect_reg(2'd0, 32'h0FF0_7000, "R9 cycle flag cleared");

    // R11 write beats increment
    wr(2'd2, 32'hFFFF_FFFF);
    wr(2'd0, 32'h0FF0_7001);
    evt_pulse[7] = 1'b1;
    wr(2'd2, 32'h0000_1234);
    evt_pulse[7] = 1'b0;
    wr(2'd0, 32'h0FF0_7000);
    expect_reg(2'd2, 32'h0000_1234, "R11 write wins");
    expect_reg(2'd0, 32'h0FF0_7000, "R11 no flag");

    // R12 counters writable at their addresses
    wr(2'd1, 32'hA5A5_0001);
    wr(2'd2, 32'h5A5A_0002);
    wr(2'd3, 32'hC3C3_0003);
    expect_reg(2'd1, 32'hA5A5_0001, "R12 cycle addr");
    expect_reg(2'd2, 32'h5A5A_0002, "R12 event0 addr");
    expect_reg(2'd3, 32'hC3C3_0003, "R12 event1 addr");

    @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule